// File: doc/BRIEF.md
# Power-Saving Clock and Reset Controller

This block sits beside a small 8-bit microcontroller core. It produces the clock enables for the CPU and for the peripherals, and it produces the core's internal reset. Software selects between two sleep depths by writing two mode bits. In the shallow mode the CPU enable is held off, and the timers, serial logic, RAM and interrupt logic keep running. In the deep mode every enable is frozen and only state retention remains. The logic is fully static, so a clock held at zero frequency loses no state.

A free-running divider marks machine-cycle boundaries, one every `MC_LEN` oscillator periods. The raw reset pin first passes through a synchronizer. A qualifier then requires the pin to stay high for `QUAL_MC` whole machine cycles before it raises the internal reset. An enabled interrupt brings the core out of shallow sleep on the next machine-cycle boundary. Deep sleep ends only through a qualified reset. `porN` is the power-on reset from the analog cell that brings the registers to a known state.

Top module: `psc_clkrst_ctrl`

## Requirements
- R1: While `porN` is low and right after it rises, `sysRst` is 0, `cpuClkEn` is 1, `periClkEn` is 1 and `mcTick` is 0. The machine-cycle counter starts at 0.
- R2: Outside deep sleep, `mcTick` is high for one clock in every `MC_LEN` (12) clocks. The first pulse comes on the 12th clock after the counter was last cleared.
- R3: The reset pin passes through a 2-flop synchronizer and is then counted. `sysRst` rises after 24 consecutive synchronized high samples, which is the 26th rising edge from the first edge that samples the pin high. A high pulse that gives 23 or fewer samples never raises `sysRst`.
- R4: `sysRst` falls after the 3rd rising edge once the pin is low. While `sysRst` is high, both mode bits are cleared and the machine-cycle counter is held at 0.
- R5: A write (`modeWr`=1 with `modeIdleIn`=1, `modePdIn`=0) accepted while `cpuClkEn` is 1 enters shallow sleep on the next edge. In shallow sleep `cpuClkEn` is 0, `periClkEn` stays 1 and `mcTick` keeps running.
- R6: A write with `modePdIn`=1 enters deep sleep. There `cpuClkEn` and `periClkEn` are 0, `mcTick` stays 0, and the machine-cycle counter is frozen.
- R7: When `modeIdleIn` and `modePdIn` are both 1 in the same write, deep sleep takes priority and interrupts do not wake the block.
- R8: In shallow sleep, a nonzero `irqWake` is remembered even if it lasts only one clock. Shallow sleep ends at the next edge where `mcTick` is high, and `cpuClkEn` returns to 1.
- R9: In deep sleep `irqWake` has no effect. Only a qualified reset (R3) leaves deep sleep.
- R10: Mode writes are ignored while `cpuClkEn` is 0 or `sysRst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| rstPinRaw | input | 1 | Raw external reset pin, active high, asynchronous |
| modeWr | input | 1 | CPU write strobe for the mode bits |
| modeIdleIn | input | 1 | Requested shallow-sleep bit |
| modePdIn | input | 1 | Requested deep-sleep bit |
| irqWake | input | IRQ_W | Enabled interrupt requests |
| cpuClkEn | output | 1 | CPU clock enable |
| periClkEn | output | 1 | Peripheral clock enable |
| mcTick | output | 1 | Machine-cycle boundary strobe |
| sysRst | output | 1 | Qualified synchronous internal reset |

## Verification
The bench builds the block with its default values: 12 clocks per machine cycle, two machine cycles of qualification and three interrupt inputs. With these values a reset qualification takes 26 edges. A whole run of sleep entries, wakes and resets therefore fits in a few hundred cycles. Pin pulses of exactly 23 and 24 synchronized samples reach both sides of the qualification limit. A one-clock interrupt pulse placed far from a machine-cycle boundary shows that the wake request is latched and that the exit waits for the boundary.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_IDLE  = 2'd1,
    PS_PDOWN = 2'd2
  } pwrState_t;

  typedef struct packed {
    logic mcRun;
    logic mcClear;
  } dpStrobe_t;
endpackage

// File: rtl/psc_datapath.sv
module psc_datapath
  import psc_pkg::*;
#(
  parameter int MC_LEN      = 12,
  parameter int QUAL_MC     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      porN,
  input  logic      rstPinRaw,
  input  dpStrobe_t strobe,
  output logic      mcTick,
  output logic      qualHit
);
  localparam int QUAL_LEN = MC_LEN * QUAL_MC;
  localparam int QW       = $clog2(QUAL_LEN + 1);
  localparam int MW       = $clog2(MC_LEN);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rstSync;
  logic [QW-1:0]          qualCnt;
  logic [MW-1:0]          mcCnt;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge porN)
        if (!porN) syncQ <= '0;
        else       syncQ <= rstPinRaw;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge porN)
        if (!porN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rstPinRaw};
    end
  endgenerate

  assign rstSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                          qualCnt <= '0;
    else if (!rstSync)                  qualCnt <= '0;
    else if (qualCnt != QW'(QUAL_LEN))  qualCnt <= qualCnt + 1'b1;
  end

  assign qualHit = rstSync && (qualCnt >= QW'(QUAL_LEN - 1));

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)              mcCnt <= '0;
    else if (strobe.mcClear) mcCnt <= '0;
    else if (strobe.mcRun)   mcCnt <= (mcCnt == MW'(MC_LEN - 1)) ? '0 : mcCnt + 1'b1;
  end

  assign mcTick = strobe.mcRun && (mcCnt == MW'(MC_LEN - 1));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!porN)
    qualCnt <= QW'(QUAL_LEN));
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!porN)
    mcCnt < MW'(MC_LEN));
  a_r6_cnt_frozen: assert property (@(posedge clk) disable iff (!porN)
    (!strobe.mcRun && !strobe.mcClear) |=> $stable(mcCnt));
  a_r4_cnt_cleared: assert property (@(posedge clk) disable iff (!porN)
    strobe.mcClear |=> (mcCnt == '0));
endmodule

// File: rtl/psc_control.sv
module psc_control
  import psc_pkg::*;
#(
  parameter int IRQ_W = 3
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             qualHit,
  input  logic             mcTick,
  input  logic             modeWr,
  input  logic             modeIdleIn,
  input  logic             modePdIn,
  input  logic [IRQ_W-1:0] irqWake,
  output logic             sysRst,
  output logic             cpuClkEn,
  output logic             periClkEn,
  output dpStrobe_t        strobe
);
  pwrState_t state;
  logic      irqSeen;
  logic      wakePend;

  assign wakePend = irqSeen || (|irqWake);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) sysRst <= 1'b0;
    else       sysRst <= qualHit;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      state   <= PS_RUN;
      irqSeen <= 1'b0;
    end else if (sysRst) begin
      state   <= PS_RUN;
      irqSeen <= 1'b0;
    end else begin
      case (state)
        PS_RUN: begin
          if (modeWr) begin
            if (modePdIn)        state <= PS_PDOWN;
            else if (modeIdleIn) state <= PS_IDLE;
          end
        end
        PS_IDLE: begin
          if (mcTick && wakePend) begin
            state   <= PS_RUN;
            irqSeen <= 1'b0;
          end else begin
            irqSeen <= wakePend;
          end
        end
        default: state <= PS_PDOWN;
      endcase
    end
  end

  assign cpuClkEn       = (state == PS_RUN);
  assign periClkEn      = (state != PS_PDOWN);
  assign strobe.mcRun   = (state != PS_PDOWN);
  assign strobe.mcClear = sysRst;

  a_r9_pd_held: assert property (@(posedge clk) disable iff (!porN)
    (state == PS_PDOWN && !sysRst) |=> (state == PS_PDOWN));
  a_r8_wake_on_tick: assert property (@(posedge clk) disable iff (!porN)
    (state == PS_IDLE && !mcTick && !sysRst) |=> (state == PS_IDLE));
  a_r4_reset_clears: assert property (@(posedge clk) disable iff (!porN)
    sysRst |=> (state == PS_RUN));
  a_r10_no_write_asleep: assert property (@(posedge clk) disable iff (!porN)
    (state != PS_RUN && !sysRst) |=> (state != PS_RUN || $past(mcTick)));
  a_r6_enable_order: assert property (@(posedge clk) disable iff (!porN)
    !periClkEn |-> !cpuClkEn);
endmodule

// File: rtl/psc_clkrst_ctrl.sv
module psc_clkrst_ctrl
  import psc_pkg::*;
#(
  parameter int MC_LEN      = 12,
  parameter int QUAL_MC     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int IRQ_W       = 3
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             rstPinRaw,
  input  logic             modeWr,
  input  logic             modeIdleIn,
  input  logic             modePdIn,
  input  logic [IRQ_W-1:0] irqWake,
  output logic             cpuClkEn,
  output logic             periClkEn,
  output logic             mcTick,
  output logic             sysRst
);
  dpStrobe_t strobe;
  logic      qualHit;

  psc_datapath #(
    .MC_LEN(MC_LEN), .QUAL_MC(QUAL_MC), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .porN(porN), .rstPinRaw(rstPinRaw),
    .strobe(strobe), .mcTick(mcTick), .qualHit(qualHit)
  );

  psc_control #(.IRQ_W(IRQ_W)) u_ctl (
    .clk(clk), .porN(porN), .qualHit(qualHit), .mcTick(mcTick),
    .modeWr(modeWr), .modeIdleIn(modeIdleIn), .modePdIn(modePdIn),
    .irqWake(irqWake), .sysRst(sysRst), .cpuClkEn(cpuClkEn),
    .periClkEn(periClkEn), .strobe(strobe)
  );
endmodule

// File: tb/psc_clkrst_ctrl_bench.sv
`timescale 1ns/1ps
module psc_clkrst_ctrl_bench;
  localparam int ML = 12;
  localparam int QL = 24;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic pin = 1'b0;
  logic modeWr = 1'b0, modeIdleIn = 1'b0, modePdIn = 1'b0;
  logic [IW-1:0] irq = '0;
  logic cpuClkEn, periClkEn, mcTick, sysRst;

  int compared = 0, mismatched = 0, cycles = 0;
  string curReq = "R1";

  // reference model state
  bit mS1, mS2, mRst, mIdle, mPd, mSeen;
  int mRun, mMc;

  always #2 clk = ~clk;

  psc_clkrst_ctrl #(.MC_LEN(ML), .QUAL_MC(2), .SYNC_STAGES(2), .IRQ_W(IW)) u_psc_clkrst_ctrl (
    .clk(clk), .porN(porN), .rstPinRaw(pin), .modeWr(modeWr),
    .modeIdleIn(modeIdleIn), .modePdIn(modePdIn), .irqWake(irq),
    .cpuClkEn(cpuClkEn), .periClkEn(periClkEn), .mcTick(mcTick), .sysRst(sysRst)
  );

  always @(posedge clk or negedge porN) begin
    bit oS1, oS2, oRst, oIdle, oPd, oSeen, hit, cpuOn, wake, tick;
    int oRun, oMc;
    if (!porN) begin
      mS1 = 0; mS2 = 0; mRst = 0; mIdle = 0; mPd = 0; mSeen = 0; mRun = 0; mMc = 0;
    end else begin
      oS1 = mS1; oS2 = mS2; oRst = mRst; oIdle = mIdle; oPd = mPd; oSeen = mSeen;
      oRun = mRun; oMc = mMc;
      mS1 = pin; mS2 = oS1;
      hit = oS2 && (oRun >= QL - 1);
      if (oS2) begin if (oRun < QL) mRun = oRun + 1; end else mRun = 0;
      mRst = hit;
      cpuOn = !(oIdle || oPd);
      tick = !oPd && (oMc == ML - 1);
      if (oRst) begin
        mIdle = 0; mPd = 0; mSeen = 0; mMc = 0;
      end else begin
        wake = oSeen || (|irq);
        if (oIdle && !oPd) begin
          if (tick && wake) begin mIdle = 0; mSeen = 0; end
          else mSeen = wake;
        end else if (modeWr && cpuOn) begin
          mIdle = modeIdleIn; mPd = modePdIn;
        end
        if (!oPd) mMc = (oMc == ML - 1) ? 0 : oMc + 1;
      end
    end
  end

  task automatic check(string what, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", curReq, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    check("sysRst", sysRst, mRst);
    check("cpuClkEn", cpuClkEn, !(mIdle || mPd));
    check("periClkEn", periClkEn, !mPd);
    check("mcTick", mcTick, !mPd && (mMc == ML - 1));
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit idle, bit pd);
    modeWr = 1'b1; modeIdleIn = idle; modePdIn = pd;
    cyc(1);
    modeWr = 1'b0; modeIdleIn = 1'b0; modePdIn = 1'b0;
  endtask

  task automatic pinPulse(int n);
    pin = 1'b1; cyc(n); pin = 1'b0; cyc(6);
  endtask

  initial begin
    // R1: power-on state
    curReq = "R1";
    #1;
    check("R1 sysRst at POR", sysRst, 1'b0);
    check("R1 cpuClkEn at POR", cpuClkEn, 1'b1);
    check("R1 periClkEn at POR", periClkEn, 1'b1);
    cyc(2); porN = 1'b1;
    cyc(1);
    curReq = "R2"; cyc(40);
    curReq = "R5"; wr(1, 0); cyc(15);
    curReq = "R10"; wr(0, 1); cyc(3);
    check("R10 pd write ignored in idle", periClkEn, 1'b1);
    curReq = "R8"; cyc(3); irq = 3'b010; cyc(1); irq = '0; cyc(20);
    check("R8 woke from idle", cpuClkEn, 1'b1);
    curReq = "R6"; wr(0, 1); cyc(30);
    check("R6 peripherals frozen", periClkEn, 1'b0);
    curReq = "R9"; irq = 3'b111; cyc(25); irq = '0;
    check("R9 irq ignored in pd", periClkEn, 1'b0);
    curReq = "R3"; pinPulse(23);
    check("R3 short pulse gives no reset", periClkEn, 1'b0);
    pinPulse(24);
    curReq = "R4"; cyc(10);
    check("R4 pd left via reset", cpuClkEn, 1'b1);
    curReq = "R7"; wr(1, 1); irq = 3'b001; cyc(30); irq = '0;
    check("R7 pd wins over idle", cpuClkEn, 1'b0);
    curReq = "R3"; pin = 1'b1; cyc(40);
    curReq = "R10"; wr(1, 0); cyc(2);
    check("R10 write ignored in reset", cpuClkEn, 1'b1);
    curReq = "R4"; pin = 1'b0; cyc(20);
    curReq = "R2"; cyc(30);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule